// File: doc/BRIEF.md
# Serial NOR Flash Command Engine

This block sends short commands to serial NOR flash devices under software control. Software sets up a mode word that holds the clock divider, the chip-select recovery time, the per-device enables and the software-mode switch. It places up to four outgoing bytes in a transmit word. It then writes a command word that gives the outgoing and incoming byte counts, the target device and a go bit. The engine drives a mode 0 serial link on one of four chip selects. It shifts the outgoing bytes out, then clocks the incoming bytes into a receive word.

After the last bit, the engine holds the chip select inactive for a programmable recovery time. It then raises a sticky completion flag, which can also drive an interrupt line. Typical uses are identification reads (one opcode out, three bytes in) and sector erases (an opcode and a 24-bit address out, nothing in).

Registers are reached through a single-cycle write strobe with a word index. Reads are combinational on the same index.

Top module: `sfc_engine`

## Requirements
- R1: Reset state: all chip selects are high (inactive), `sclk`, `mosi` and `irq` are low, and the status word (index 2) reads zero.
- R2: A write to the command word (index 1) with bit 7 set starts a transfer only when mode word (index 0) bit 28 is set and the enable bit in mode bits [3:0] for the selected device is set. Otherwise no chip select moves and no completion is reported.
- R3: Command bits [13:12] pick the device. Only that chip select goes low during a transfer, and at most one is low at any time.
- R4: Mode bits [15:8] give the divider P; a value below 2 acts as 2. Each bit lasts P clocks: `sclk` is low for the first P−P/2 clocks and high for the last P/2 clocks. `sclk` is low whenever no bits are being shifted.
- R5: Command bits [3:0] give the outgoing count, and values above 4 act as 4. Outgoing bytes are taken from the transmit word (index 3) starting with bits [7:0], and each byte is sent MSB first. `mosi` is 0 during incoming bits and when idle.
- R6: Command bits [6:4] give the incoming count, and values above 4 act as 4. `miso` is sampled in the last clock of each incoming bit and shifted into the receive word (index 4) from the LSB. The first incoming byte therefore ends in the highest counted byte position. The receive word is cleared when a transfer starts.
- R7: After the last bit, every chip select stays high for (D+1)·P clocks, where D is mode bits [7:4]. Then status bit 8 (done) is set.
- R8: Status bit 15 (busy) is high from the clock after the start until done is set. While busy, a command write is ignored: it does not restart the transfer, change the device or alter the stored command. Command reads return the stored counts, enable and device, with bit 7 reading 0.
- R9: `irq` equals done AND command bit 8, where bit 8 is held from the last accepted command write.
- R10: A status write with bit 8 clear clears done and so drops `irq`. A status write with bit 8 set leaves done unchanged.
- R11: A start with both counts zero sets done on the next clock, without any chip select or `sclk` activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index (0 mode, 1 command, 2 status, 3 transmit, 4 receive) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 4 | Active-low chip selects, one per device |
| mosi | output | 1 | Serial data to the devices |
| miso | input | 1 | Serial data from the devices |
| irq | output | 1 | Completion interrupt, level |

## Verification
The bench compares chip selects, `sclk`, `mosi`, `irq` and the status word against its own model on every clock. A bit counter or divider phase that slips shows up within one bit period, as an `sclk` edge or a `mosi` value in the wrong clock. A corrupt latched device number moves the active chip select in the first clock of the transfer. A recovery counter that is off by one shifts the busy fall and the done rise by P clocks. Receive packing errors are visible only when the receive word is read back after completion.

// File: rtl/sfc_pkg.sv
// Shared register indices, field positions and sequencer states for the
// serial flash command engine. Field positions are fixed by software.
package sfc_pkg;

    typedef enum logic [2:0] {
        RA_MODE = 3'd0,
        RA_CMD  = 3'd1,
        RA_STAT = 3'd2,
        RA_TXD  = 3'd3,
        RA_RXD  = 3'd4
    } reg_sel_e;

    localparam int MODE_SW_BIT    = 28;
    localparam int MODE_DSEL_LSB  = 4;
    localparam int MODE_PRESC_LSB = 8;

    localparam int CMD_TX_LSB     = 0;
    localparam int CMD_RX_LSB     = 4;
    localparam int CMD_GO_BIT     = 7;
    localparam int CMD_IEN_BIT    = 8;
    localparam int CMD_BANK_LSB   = 12;

    localparam int STAT_DONE_BIT  = 8;
    localparam int STAT_BUSY_BIT  = 15;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_SHIFT = 2'd1,
        SH_GAP   = 2'd2
    } sh_state_e;

endpackage

// File: rtl/sfc_regs.sv
// Register file and launch decode.
// Holds mode, command, transmit and done state, and decodes a start request.
// Assumes a single write per clock. While busy, command writes are dropped.
module sfc_regs
    import sfc_pkg::*;
#(
    parameter int NUM_CS    = 4,
    parameter int PRESC_W   = 8,
    parameter int DSEL_W    = 4,
    parameter int MAX_BYTES = 4,
    localparam int BANK_W   = $clog2(NUM_CS),
    localparam int CNT_W    = $clog2(MAX_BYTES + 1),
    localparam int WORD_W   = 8 * MAX_BYTES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [2:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                busy,
    input  logic                fin,
    input  logic [WORD_W-1:0]   rx_word,
    output logic                launch,
    output logic [CNT_W-1:0]    l_txn,
    output logic [CNT_W-1:0]    l_rxn,
    output logic [BANK_W-1:0]   l_bank,
    output logic [PRESC_W-1:0]  l_presc,
    output logic [DSEL_W-1:0]   l_dsel,
    output logic [WORD_W-1:0]   tx_word,
    output logic                done,
    output logic                ien
);

    logic                sw_q;
    logic [NUM_CS-1:0]   en_q;
    logic [DSEL_W-1:0]   dsel_q;
    logic [PRESC_W-1:0]  presc_q;
    logic [CNT_W-1:0]    txn_q, rxn_q;
    logic [BANK_W-1:0]   bank_q;
    logic [31:0]         txd_q;
    logic                cmd_wr;
    logic [CNT_W-1:0]    w_txn, w_rxn;
    logic [BANK_W-1:0]   w_bank;
    wire                 unused_wdata = ^reg_wdata;

    // Clamp a requested byte count to the supported maximum.
    function automatic logic [CNT_W-1:0] clip(input logic [3:0] v);
        return (v > 4'(MAX_BYTES)) ? CNT_W'(MAX_BYTES) : CNT_W'(v);
    endfunction

    // Decode the command fields and the start condition.
    always_comb begin
        cmd_wr = reg_we && (reg_addr == RA_CMD) && !busy;
        w_txn  = clip(reg_wdata[CMD_TX_LSB +: 4]);
        w_rxn  = clip({1'b0, reg_wdata[CMD_RX_LSB +: 3]});
        w_bank = reg_wdata[CMD_BANK_LSB +: BANK_W];
        launch = cmd_wr && reg_wdata[CMD_GO_BIT] && sw_q && en_q[w_bank];
    end

    assign l_txn   = w_txn;
    assign l_rxn   = w_rxn;
    assign l_bank  = w_bank;
    assign l_presc = presc_q;
    assign l_dsel  = dsel_q;
    assign tx_word = txd_q[WORD_W-1:0];

    // Mode word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q    <= 1'b0;
            en_q    <= '0;
            dsel_q  <= '0;
            presc_q <= '0;
        end else if (reg_we && reg_addr == RA_MODE) begin
            sw_q    <= reg_wdata[MODE_SW_BIT];
            en_q    <= reg_wdata[NUM_CS-1:0];
            dsel_q  <= reg_wdata[MODE_DSEL_LSB +: DSEL_W];
            presc_q <= reg_wdata[MODE_PRESC_LSB +: PRESC_W];
        end
    end

    // Command word storage, only accepted when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txn_q  <= '0;
            rxn_q  <= '0;
            bank_q <= '0;
            ien    <= 1'b0;
        end else if (cmd_wr) begin
            txn_q  <= w_txn;
            rxn_q  <= w_rxn;
            bank_q <= w_bank;
            ien    <= reg_wdata[CMD_IEN_BIT];
        end
    end

    // Transmit word storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            txd_q <= '0;
        else if (reg_we && reg_addr == RA_TXD)
            txd_q <= reg_wdata;
    end

    // Sticky completion flag; completion wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else if (fin)
            done <= 1'b1;
        else if (reg_we && reg_addr == RA_STAT && !reg_wdata[STAT_DONE_BIT])
            done <= 1'b0;
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_MODE: begin
                reg_rdata[MODE_SW_BIT]                 = sw_q;
                reg_rdata[NUM_CS-1:0]                  = en_q;
                reg_rdata[MODE_DSEL_LSB +: DSEL_W]     = dsel_q;
                reg_rdata[MODE_PRESC_LSB +: PRESC_W]   = presc_q;
            end
            RA_CMD: begin
                reg_rdata[CMD_TX_LSB +: CNT_W]         = txn_q;
                reg_rdata[CMD_RX_LSB +: CNT_W]         = rxn_q;
                reg_rdata[CMD_IEN_BIT]                 = ien;
                reg_rdata[CMD_BANK_LSB +: BANK_W]      = bank_q;
            end
            RA_STAT: begin
                reg_rdata[STAT_DONE_BIT]               = done;
                reg_rdata[STAT_BUSY_BIT]               = busy;
            end
            RA_TXD:  reg_rdata = txd_q;
            RA_RXD:  reg_rdata = 32'(rx_word);
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sfc_clkgen.sv
// Bit-period divider. While run is high, counts P clocks per bit, marks
// the high half of the serial clock and the last clock of each bit.
// Assumes presc >= 2 whenever run is high.
module sfc_clkgen #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [PRESC_W-1:0] presc,
    output logic               hi_phase,
    output logic               bit_end
);

    logic [PRESC_W-1:0] cnt;
    logic [PRESC_W-1:0] low_len;

    assign low_len  = presc - (presc >> 1);
    assign hi_phase = run && (cnt >= low_len);
    assign bit_end  = run && (cnt == presc - 1'b1);

    // Phase counter within one bit period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (bit_end)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/sfc_shifter.sv
// Transfer sequencer. Latches a launch, drives one chip select, shifts
// outgoing bytes MSB first, gathers incoming bits, then waits out the
// chip-select recovery time before signalling completion.
// Assumes launch only arrives while idle.
module sfc_shifter
    import sfc_pkg::*;
#(
    parameter int NUM_CS    = 4,
    parameter int PRESC_W   = 8,
    parameter int DSEL_W    = 4,
    parameter int MAX_BYTES = 4,
    localparam int BANK_W   = $clog2(NUM_CS),
    localparam int CNT_W    = $clog2(MAX_BYTES + 1),
    localparam int WORD_W   = 8 * MAX_BYTES,
    localparam int BIT_W    = $clog2(2 * WORD_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic [CNT_W-1:0]   l_txn,
    input  logic [CNT_W-1:0]   l_rxn,
    input  logic [BANK_W-1:0]  l_bank,
    input  logic [PRESC_W-1:0] l_presc,
    input  logic [DSEL_W-1:0]  l_dsel,
    input  logic [WORD_W-1:0]  tx_word,
    input  logic               miso,
    input  logic               hi_phase,
    input  logic               bit_end,
    output logic               run,
    output logic [PRESC_W-1:0] presc_eff,
    output logic [NUM_CS-1:0]  cs_n,
    output logic               sclk,
    output logic               mosi,
    output logic               busy,
    output logic               fin,
    output logic [WORD_W-1:0]  rx_word
);

    sh_state_e          st;
    logic [BIT_W-1:0]   bitn, nbits_q, rx_start_q, l_nbits;
    logic [DSEL_W-1:0]  dsel_q, gcnt;
    logic [BANK_W-1:0]  bank_q;
    logic [WORD_W-1:0]  txsh, tx_load;
    logic               start_ok;

    assign l_nbits  = BIT_W'({l_txn, 3'b000}) + BIT_W'({l_rxn, 3'b000});
    assign start_ok = (st == SH_IDLE) && launch;

    // Arrange counted outgoing bytes so byte 0 leaves first; zero the rest.
    always_comb begin
        tx_load = '0;
        for (int i = 0; i < MAX_BYTES; i++) begin
            if (CNT_W'(i) < l_txn)
                tx_load[WORD_W-1-8*i -: 8] = tx_word[8*i +: 8];
        end
    end

    // Sequencer state, bit position and latched transfer settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= SH_IDLE;
            bitn       <= '0;
            nbits_q    <= '0;
            rx_start_q <= '0;
            dsel_q     <= '0;
            gcnt       <= '0;
            bank_q     <= '0;
            presc_eff  <= PRESC_W'(2);
            txsh       <= '0;
        end else begin
            unique case (st)
                SH_IDLE: begin
                    if (start_ok && l_nbits != '0) begin
                        st         <= SH_SHIFT;
                        bitn       <= '0;
                        nbits_q    <= l_nbits;
                        rx_start_q <= BIT_W'({l_txn, 3'b000});
                        dsel_q     <= l_dsel;
                        bank_q     <= l_bank;
                        presc_eff  <= (l_presc < PRESC_W'(2)) ? PRESC_W'(2) : l_presc;
                        txsh       <= tx_load;
                    end
                end
                SH_SHIFT: begin
                    if (bit_end) begin
                        txsh <= txsh << 1;
                        if (bitn == nbits_q - 1'b1) begin
                            st   <= SH_GAP;
                            gcnt <= '0;
                        end else begin
                            bitn <= bitn + 1'b1;
                        end
                    end
                end
                SH_GAP: begin
                    if (bit_end) begin
                        if (gcnt == dsel_q)
                            st <= SH_IDLE;
                        else
                            gcnt <= gcnt + 1'b1;
                    end
                end
                default: st <= SH_IDLE;
            endcase
        end
    end

    // Incoming shift register: cleared on start, filled during receive bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_word <= '0;
        else if (start_ok)
            rx_word <= '0;
        else if (st == SH_SHIFT && bit_end && bitn >= rx_start_q)
            rx_word <= {rx_word[WORD_W-2:0], miso};
    end

    assign run  = (st != SH_IDLE);
    assign busy = (st != SH_IDLE);
    assign sclk = (st == SH_SHIFT) && hi_phase;
    assign mosi = (st == SH_SHIFT) && txsh[WORD_W-1];
    assign fin  = ((st == SH_GAP) && bit_end && (gcnt == dsel_q)) ||
                  (start_ok && l_nbits == '0);

    // One active-low select per device.
    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_n[i] = !((st == SH_SHIFT) && (bank_q == BANK_W'(i)));
    end

endmodule

// File: rtl/sfc_engine.sv
// Top of the serial flash command engine: register file, bit divider and
// transfer sequencer. Mode 0 serial link, single data line each way.
// Assumes software keeps the serial clock within the devices' limit.
module sfc_engine #(
    parameter int NUM_CS    = 4,
    parameter int PRESC_W   = 8,
    parameter int DSEL_W    = 4,
    parameter int MAX_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              sclk,
    output logic [NUM_CS-1:0] cs_n,
    output logic              mosi,
    input  logic              miso,
    output logic              irq
);

    localparam int BANK_W = $clog2(NUM_CS);
    localparam int CNT_W  = $clog2(MAX_BYTES + 1);
    localparam int WORD_W = 8 * MAX_BYTES;

    logic               busy, fin, done, ien, launch, run, hi_phase, bit_end;
    logic [CNT_W-1:0]   l_txn, l_rxn;
    logic [BANK_W-1:0]  l_bank;
    logic [PRESC_W-1:0] l_presc, presc_eff;
    logic [DSEL_W-1:0]  l_dsel;
    logic [WORD_W-1:0]  tx_word, rx_word;

    sfc_regs #(
        .NUM_CS(NUM_CS), .PRESC_W(PRESC_W), .DSEL_W(DSEL_W), .MAX_BYTES(MAX_BYTES)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .fin(fin),
        .rx_word(rx_word), .launch(launch), .l_txn(l_txn), .l_rxn(l_rxn),
        .l_bank(l_bank), .l_presc(l_presc), .l_dsel(l_dsel), .tx_word(tx_word),
        .done(done), .ien(ien)
    );

    sfc_clkgen #(.PRESC_W(PRESC_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(run), .presc(presc_eff),
        .hi_phase(hi_phase), .bit_end(bit_end)
    );

    sfc_shifter #(
        .NUM_CS(NUM_CS), .PRESC_W(PRESC_W), .DSEL_W(DSEL_W), .MAX_BYTES(MAX_BYTES)
    ) u_shift (
        .clk(clk), .rst_n(rst_n), .launch(launch), .l_txn(l_txn), .l_rxn(l_rxn),
        .l_bank(l_bank), .l_presc(l_presc), .l_dsel(l_dsel), .tx_word(tx_word),
        .miso(miso), .hi_phase(hi_phase), .bit_end(bit_end), .run(run),
        .presc_eff(presc_eff), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .busy(busy), .fin(fin), .rx_word(rx_word)
    );

    assign irq = done && ien;

endmodule

// File: rtl/sfc_engine_chk.sv
// Temporal checks on the serial flash command engine, attached by bind.
module sfc_engine_chk
    import sfc_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [2:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              sclk,
    input logic [NUM_CS-1:0] cs_n,
    input logic              irq,
    input logic              busy,
    input logic              done
);

    // R3
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R4
    sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> (cs_n != '1));

    // R2
    idle_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n == '1));

    // R7
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R8
    cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != '1) |=> ((cs_n == '1) || $stable(cs_n)));

    // R9
    irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);

    // R10
    stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == RA_STAT && !reg_wdata[STAT_DONE_BIT] && !busy) |=> !done);

endmodule

bind sfc_engine sfc_engine_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .sclk(sclk), .cs_n(cs_n), .irq(irq),
    .busy(busy), .done(done)
);

// File: tb/sfc_engine_test.sv
module sfc_engine_test;
    import sfc_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = RA_STAT;
    logic [31:0] reg_wdata = '0;
    logic        miso = 1'b0;
    wire  [31:0] reg_rdata;
    wire         sclk, mosi, irq;
    wire  [3:0]  cs_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfc_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk),
        .cs_n(cs_n), .mosi(mosi), .miso(miso), .irq(irq)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0]  resp [4];
    bit          m_sw;
    logic [3:0]  m_en;
    int          m_dsel, m_presc, m_ien, m_done, m_busy, m_t, m_total;
    int          m_shift_len, m_P, m_L, m_bank, m_txn;
    logic [31:0] m_txd, m_txl, m_rx_exp;
    bit          b0, dset;
    int          txn, rxn, nb;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sw = 0; m_en = 0; m_dsel = 0; m_presc = 0; m_ien = 0; m_done = 0;
            m_busy = 0; m_t = 0; m_total = 0; m_shift_len = 0; m_P = 2; m_L = 1;
            m_bank = 0; m_txn = 0; m_txd = 0; m_txl = 0; m_rx_exp = 0;
        end else begin
            b0 = m_busy;
            dset = 0;
            if (m_busy) begin
                m_t++;
                if (m_t == m_total) begin
                    m_busy = 0;
                    dset = 1;
                end
            end
            if (reg_we) begin
                case (reg_addr)
                    RA_MODE: begin
                        m_sw = reg_wdata[28]; m_en = reg_wdata[3:0];
                        m_dsel = reg_wdata[7:4]; m_presc = reg_wdata[15:8];
                    end
                    RA_CMD: if (!b0) begin
                        txn = reg_wdata[3:0];   if (txn > 4) txn = 4;
                        rxn = reg_wdata[6:4];   if (rxn > 4) rxn = 4;
                        m_ien = reg_wdata[8];
                        if (reg_wdata[7] && m_sw && m_en[reg_wdata[13:12]]) begin
                            m_bank = reg_wdata[13:12];
                            m_P = (m_presc < 2) ? 2 : m_presc;
                            m_L = m_P - m_P / 2;
                            nb = 8 * (txn + rxn);
                            m_shift_len = nb * m_P;
                            m_total = (nb + m_dsel + 1) * m_P;
                            m_txl = m_txd;
                            m_txn = txn;
                            m_rx_exp = 0;
                            for (int i = 0; i < rxn; i++) m_rx_exp = (m_rx_exp << 8) | 32'(resp[i]);
                            m_t = 0;
                            if (nb == 0) dset = 1; else m_busy = 1;
                        end
                    end
                    RA_STAT: if (!reg_wdata[8]) m_done = 0;
                    RA_TXD:  m_txd = reg_wdata;
                    default: ;
                endcase
            end
            if (dset) m_done = 1;
        end
    end

    // Device responder: next incoming bit after each falling serial clock.
    logic prev_sclk = 1'b0;
    logic prev_all  = 1'b1;
    int   fall_cnt  = 0;
    int   s;
    always @(negedge clk) begin
        if (prev_all && !(&cs_n)) fall_cnt = 0;
        else if (prev_sclk && !sclk) fall_cnt++;
        prev_all  = &cs_n;
        prev_sclk = sclk;
        s = fall_cnt - 8 * m_txn;
        miso <= (s >= 0 && s < 32) ? resp[s/8][7 - s%8] : 1'b0;
    end

    // Per-clock comparison of pins and status against the model.
    bit   shift_e, sclk_e, mosi_e;
    logic [3:0]  cs_e;
    logic [31:0] stat_e;
    int   j;
    always @(negedge clk) begin
        if (rst_n) begin
            shift_e = m_busy && (m_t < m_shift_len);
            cs_e = 4'hF;
            if (shift_e) cs_e[m_bank] = 1'b0;
            j = m_t / m_P;
            sclk_e = shift_e && ((m_t % m_P) >= m_L);
            mosi_e = shift_e && (j < 8 * m_txn) && m_txl[8*(j/8) + 7 - j%8];
            chk(cs_n == cs_e, "R3 R7 chip select", 32'(cs_n), 32'(cs_e));
            chk(sclk == sclk_e, "R4 sclk", 32'(sclk), 32'(sclk_e));
            chk(mosi == mosi_e, "R5 mosi", 32'(mosi), 32'(mosi_e));
            chk(irq == (m_done && m_ien), "R9 irq", 32'(irq), 32'(m_done && m_ien));
            if (reg_addr == RA_STAT && !reg_we) begin
                stat_e = (32'(m_busy) << 15) | (32'(m_done) << 8);
                chk(reg_rdata == stat_e, "R7 R8 status", reg_rdata, stat_e);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0; reg_addr = RA_STAT; reg_wdata = '0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        chk(reg_rdata == exp, req, reg_rdata, exp);
        @(posedge clk); #1;
        reg_addr = RA_STAT;
    endtask

    task automatic wait_idle();
        @(posedge clk); #1;
        while (m_busy) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        resp[0] = 8'hC2; resp[1] = 8'h20; resp[2] = 8'h16; resp[3] = 8'h5A;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(cs_n == 4'hF, "R1 cs_n", 32'(cs_n), 32'hF);
        chk(sclk == 1'b0, "R1 sclk", 32'(sclk), 0);
        chk(mosi == 1'b0, "R1 mosi", 32'(mosi), 0);
        chk(irq == 1'b0, "R1 irq", 32'(irq), 0);
        chk(reg_rdata == 32'h0, "R1 status", reg_rdata, 0);
        rst_n = 1'b1;

        // R2: software mode off, start ignored
        wr(RA_MODE, 32'h0000_042F);
        wr(RA_TXD, 32'h0000_009F);
        wr(RA_CMD, 32'h0000_01B1);
        repeat (20) @(posedge clk);
        rd_chk(RA_STAT, 32'h0, "R2 no start without software mode");
        // R2: device disabled, start ignored
        wr(RA_MODE, 32'h1000_042E);
        wr(RA_CMD, 32'h0000_01B1);
        repeat (20) @(posedge clk);
        rd_chk(RA_STAT, 32'h0, "R2 no start on disabled device");

        // R5 R6 identification read: 1 out, 3 in, device 0, interrupt on
        wr(RA_MODE, 32'h1000_042F);
        wr(RA_CMD, 32'h0000_01B1);
        wait_idle();
        rd_chk(RA_STAT, 32'h0000_0100, "R7 done after read");
        chk(irq == 1'b1, "R9 irq raised", 32'(irq), 1);
        rd_chk(RA_RXD, 32'h00C2_2016, "R6 receive packing");

        // R10: write with bit 8 set keeps done, write of zero clears
        wr(RA_STAT, 32'h0000_0100);
        rd_chk(RA_STAT, 32'h0000_0100, "R10 keep done");
        wr(RA_STAT, 32'h0);
        rd_chk(RA_STAT, 32'h0, "R10 clear done");
        chk(irq == 1'b0, "R10 irq cleared", 32'(irq), 0);

        // R5 R8 four-byte command on device 2, odd divider, no recovery extension
        wr(RA_MODE, 32'h1000_030F);
        wr(RA_TXD, 32'h5634_12D8);
        wr(RA_CMD, 32'h0000_2084);
        wr(RA_CMD, 32'h0000_3081);   // R8 ignored while busy
        wait_idle();
        rd_chk(RA_CMD, 32'h0000_2004, "R8 command kept while busy");
        chk(irq == 1'b0, "R9 irq masked", 32'(irq), 0);
        wr(RA_STAT, 32'h0);

        // R4 divider zero acts as two; 2 out 2 in on device 3
        wr(RA_MODE, 32'h1000_001F);
        wr(RA_TXD, 32'h0000_A55A);
        wr(RA_CMD, 32'h0000_31A2);
        wait_idle();
        rd_chk(RA_RXD, 32'h0000_C220, "R6 two incoming bytes");
        wr(RA_STAT, 32'h0);

        // R5 R6 counts above four are clipped
        wr(RA_MODE, 32'h1000_053F);
        wr(RA_TXD, 32'h1122_3344);
        wr(RA_CMD, 32'h0000_10E7);
        wait_idle();
        rd_chk(RA_RXD, 32'hC220_165A, "R6 clipped incoming count");
        rd_chk(RA_CMD, 32'h0000_1044, "R5 clipped counts stored");
        wr(RA_STAT, 32'h0);

        // R7 long recovery with divider 7
        wr(RA_MODE, 32'h1000_07FF);
        wr(RA_TXD, 32'h0000_0006);
        wr(RA_CMD, 32'h0000_1081);
        wait_idle();
        rd_chk(RA_STAT, 32'h0000_0100, "R7 done after long recovery");
        wr(RA_STAT, 32'h0);

        // R11 zero-length start
        wr(RA_CMD, 32'h0000_0180);
        rd_chk(RA_STAT, 32'h0000_0100, "R11 immediate done");
        chk(irq == 1'b1, "R11 irq", 32'(irq), 1);
        repeat (5) @(posedge clk);
        finish_run();
    end

endmodule